// File: doc/BRIEF.md
# Channel Overload Restart and Diagnostic Sequencer

This block decides, for a single amplifier output channel, what happens after the short-circuit protection trips. A coarse time base arrives as a one-cycle `tick` pulse, nominally once per millisecond, from a prescaler outside the block. Analog sensing lives elsewhere. The overload itself (`trip`) and the class of the fault (short to ground, short to supply, short across the load) all arrive as synchronous flags.

There are two behaviours. With diagnostics off, or with no cycle armed, the channel is switched off and re-examined every `CHECK_TICKS` ticks. It turns back on at the first check that finds the overload gone. With diagnostics on and a cycle armed, the block first waits `CHECK_TICKS` ticks so that a brief spike is not mistaken for a fault. If the overload is still there at that check, a measurement cycle of `CYCLE_TICKS` ticks runs. A class bit is latched only if its flag was high on every tick of the window. After the cycle, the channel falls back to restart behaviour and the result is held for the host. The next cycle is armed only by a host read strobe.

A result from a turn-on test can be loaded from outside, including the open-load bit. That result is kept until a measurement cycle latches a short.

Top module: `chan_fault_seq`

## Requirements
- R1: After reset, `ch_en` is 1, `flt` is 0, `cycle_done` is 0 and a diagnostic cycle is armed.
- R2: While the channel is enabled, a high `trip` drives `ch_en` low on the next cycle. If diagnostics are off or no cycle is armed, the channel stays off for as long as `trip` is still high at the checks.
- R3: In restart behaviour, `trip` is examined on every `CHECK_TICKS`-th tick. `ch_en` returns to 1 in the cycle after the first such tick at which `trip` is low, and never earlier.
- R4: With `diag_en` high and a cycle armed, a trip that has cleared by the check `CHECK_TICKS` ticks later re-enables the channel. No cycle runs, and `flt` and `cycle_done` keep their values.
- R5: If `trip` is still high at that check, a cycle of `CYCLE_TICKS` ticks runs. After its last tick, `cycle_done` becomes 1 and the channel stays off in restart behaviour.
- R6: At the end of a cycle, `flt[0]` (ground short), `flt[1]` (supply short) and `flt[2]` (short across the load) are each set to the AND of their class flag over every tick of the window.
- R7: A completed cycle disarms the block. Only `host_rd` re-arms it. `host_rd` clears `cycle_done` and leaves `flt` unchanged.
- R8: `flt[3]` (open load) is written only by `ton_wr`, which loads all of `flt` from `ton_flt`. A measurement cycle never sets it, and clears it only when the cycle latches at least one short bit.
- R9: Dropping `diag_en` during the spike check or the cycle aborts to restart behaviour. `flt` and `cycle_done` are left unchanged and the armed state is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time-base pulse (nominally 1 ms) |
| diag_en | input | 1 | Diagnostic behaviour enable |
| trip | input | 1 | Short-circuit protection active |
| cls_gnd | input | 1 | Fault class: short to ground |
| cls_vs | input | 1 | Fault class: short to supply |
| cls_load | input | 1 | Fault class: short across the load |
| host_rd | input | 1 | Host read strobe; arms the next cycle |
| ton_wr | input | 1 | Load a turn-on test result into `flt` |
| ton_flt | input | 4 | Turn-on result, same bit layout as `flt` |
| ch_en | output | 1 | Channel enable |
| flt | output | 4 | Latched fault bits {open, load short, supply short, ground short} |
| cycle_done | output | 1 | A completed cycle awaits a host read |

## Verification
The bench builds the block with `CHECK_TICKS` = 2 and `CYCLE_TICKS` = 5. The spike check and the full cycle then take only a handful of ticks, so the boundary between the last tick that keeps the channel off and the tick that re-enables it can be stepped through one tick at a time. The short window also makes it cheap to sweep every one of the eight combinations of the three class flags through a complete cycle, each starting from a preloaded open-load bit. It also allows a single dropped flag inside the window, an abort in mid-cycle, and the disarmed path where a second trip must not start a cycle.

// File: rtl/chfs_pkg.sv
package chfs_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_OFF   = 2'd1,
        ST_SPIKE = 2'd2,
        ST_DIAG  = 2'd3
    } chfs_state_e;

    typedef struct packed {
        logic open;
        logic load;
        logic vs;
        logic gnd;
    } chfs_flt_t;

    function automatic int cnt_width(input int a, input int b);
        return $clog2((a > b) ? a : b) + 1;
    endfunction

endpackage

// File: rtl/chfs_tick_cnt.sv
module chfs_tick_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          hit
);
    logic [CW-1:0] cnt;

    assign hit = tick && (cnt == (limit - CW'(1)));

    always_ff @(posedge clk) begin
        if (rst || clr || hit) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/chfs_ctrl.sv
module chfs_ctrl
    import chfs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        trip,
    input  logic        diag_en,
    input  logic        hit,
    input  logic        host_rd,
    output chfs_state_e state,
    output logic        cnt_clr,
    output logic        start,
    output logic        commit
);
    chfs_state_e state_n;
    logic        armed;

    always_comb begin
        state_n = state;
        start   = 1'b0;
        commit  = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (trip) state_n = (diag_en && armed) ? ST_SPIKE : ST_OFF;
            end
            ST_OFF: begin
                if (hit && !trip) state_n = ST_RUN;
            end
            ST_SPIKE: begin
                if (!diag_en) begin
                    state_n = ST_OFF;
                end else if (hit) begin
                    state_n = trip ? ST_DIAG : ST_RUN;
                    start   = trip;
                end
            end
            ST_DIAG: begin
                if (!diag_en) begin
                    state_n = ST_OFF;
                end else if (hit) begin
                    state_n = ST_OFF;
                    commit  = 1'b1;
                end
            end
            default: state_n = ST_RUN;
        endcase
    end

    assign cnt_clr = (state == ST_RUN) || (state_n != state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            armed <= 1'b1;
        end else begin
            state <= state_n;
            if (commit)       armed <= 1'b0;
            else if (host_rd) armed <= 1'b1;
        end
    end
endmodule

// File: rtl/chfs_store.sv
module chfs_store
    import chfs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      in_diag,
    input  logic      start,
    input  logic      commit,
    input  logic [2:0] cls,
    input  logic      host_rd,
    input  logic      ton_wr,
    input  chfs_flt_t ton_val,
    output chfs_flt_t flt,
    output logic      done
);
    logic [2:0] acc;
    logic [2:0] result;

    assign result = acc & cls;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '1;
            flt  <= '0;
            done <= 1'b0;
        end else begin
            if (start)                acc <= '1;
            else if (in_diag && tick) acc <= result;

            if (commit) begin
                flt.gnd  <= result[0];
                flt.vs   <= result[1];
                flt.load <= result[2];
                if (|result) flt.open <= 1'b0;
            end else if (ton_wr) begin
                flt <= ton_val;
            end

            if (commit)       done <= 1'b1;
            else if (host_rd) done <= 1'b0;
        end
    end
endmodule

// File: rtl/chan_fault_seq.sv
module chan_fault_seq
    import chfs_pkg::*;
#(
    parameter int CHECK_TICKS = 1,
    parameter int CYCLE_TICKS = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       diag_en,
    input  logic       trip,
    input  logic       cls_gnd,
    input  logic       cls_vs,
    input  logic       cls_load,
    input  logic       host_rd,
    input  logic       ton_wr,
    input  logic [3:0] ton_flt,
    output logic       ch_en,
    output logic [3:0] flt,
    output logic       cycle_done
);
    localparam int CW = cnt_width(CHECK_TICKS, CYCLE_TICKS);
    localparam logic [CW-1:0] LIM_CHECK = CW'(CHECK_TICKS);
    localparam logic [CW-1:0] LIM_CYCLE = CW'(CYCLE_TICKS);

    chfs_state_e   state;
    logic          cnt_clr;
    logic          hit;
    logic          start;
    logic          commit;
    logic [CW-1:0] limit;
    chfs_flt_t     flt_q;

    assign limit = (state == ST_DIAG) ? LIM_CYCLE : LIM_CHECK;

    chfs_tick_cnt #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .tick  (tick),
        .limit (limit),
        .hit   (hit)
    );

    chfs_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .trip    (trip),
        .diag_en (diag_en),
        .hit     (hit),
        .host_rd (host_rd),
        .state   (state),
        .cnt_clr (cnt_clr),
        .start   (start),
        .commit  (commit)
    );

    chfs_store u_store (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .in_diag (state == ST_DIAG),
        .start   (start),
        .commit  (commit),
        .cls     ({cls_load, cls_vs, cls_gnd}),
        .host_rd (host_rd),
        .ton_wr  (ton_wr),
        .ton_val (chfs_flt_t'(ton_flt)),
        .flt     (flt_q),
        .done    (cycle_done)
    );

    assign ch_en = (state == ST_RUN);
    assign flt   = flt_q;
endmodule

// File: rtl/chfs_checker.sv
module chfs_checker (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       trip,
    input logic       host_rd,
    input logic       ton_wr,
    input logic       ch_en,
    input logic [3:0] flt,
    input logic       cycle_done
);
    p_off_after_trip_r2: assert property (@(posedge clk) disable iff (rst)
        (ch_en && trip) |=> !ch_en);

    p_reenable_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ch_en) |-> $past(tick));

    p_done_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(cycle_done) |-> ($past(tick) && !ch_en));

    p_read_clears_done_r7: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !tick) |=> !cycle_done);

    p_flt_held_r7: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ton_wr) |=> $stable(flt));

    p_open_not_set_r8: assert property (@(posedge clk) disable iff (rst)
        (!flt[3] && !ton_wr) |=> !flt[3]);
endmodule

bind chan_fault_seq chfs_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .trip       (trip),
    .host_rd    (host_rd),
    .ton_wr     (ton_wr),
    .ch_en      (ch_en),
    .flt        (flt),
    .cycle_done (cycle_done)
);

// File: tb/tb_chan_fault_seq.sv
`timescale 1ns/1ps
module tb_chan_fault_seq;
    localparam int CHK = 2;
    localparam int CYC = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0, diag_en = 1'b0, trip = 1'b0;
    logic       cls_gnd = 1'b0, cls_vs = 1'b0, cls_load = 1'b0;
    logic       host_rd = 1'b0, ton_wr = 1'b0;
    logic [3:0] ton_flt = 4'd0;
    logic       ch_en, cycle_done;
    logic [3:0] flt;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    chan_fault_seq #(.CHECK_TICKS(CHK), .CYCLE_TICKS(CYC)) dut (
        .clk(clk), .rst(rst), .tick(tick), .diag_en(diag_en), .trip(trip),
        .cls_gnd(cls_gnd), .cls_vs(cls_vs), .cls_load(cls_load),
        .host_rd(host_rd), .ton_wr(ton_wr), .ton_flt(ton_flt),
        .ch_en(ch_en), .flt(flt), .cycle_done(cycle_done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    // One clock with the given tick value; returns at the following negedge.
    task automatic step(input logic t);
        tick = t;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
        host_rd = 1'b0;
        ton_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1);
    endtask

    task automatic do_read();
        host_rd = 1'b1;
        step(1'b0);
    endtask

    // Enter the measurement window from RUN with diagnostics armed.
    task automatic enter_cycle();
        trip = 1'b1;
        step(1'b0);
        ticks(CHK);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: act=%0d exp=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(1'b0);
        step(1'b0);
        rst = 1'b0;
        step(1'b0);
        chk("R1", "ch_en", ch_en, 1);
        chk("R1", "flt", flt, 0);
        chk("R1", "done", cycle_done, 0);

        // R2/R3: restart behaviour with diagnostics off
        trip = 1'b1;
        step(1'b0);
        chk("R2", "ch_en after trip", ch_en, 0);
        ticks(CHK);
        chk("R2", "ch_en trip held at check", ch_en, 0);
        trip = 1'b0;
        ticks(CHK - 1);
        chk("R3", "ch_en before check tick", ch_en, 0);
        step(1'b0);
        chk("R3", "ch_en no tick", ch_en, 0);
        ticks(1);
        chk("R3", "ch_en at check tick", ch_en, 1);

        // R4: spike filtered out
        diag_en = 1'b1;
        trip = 1'b1;
        step(1'b0);
        trip = 1'b0;
        chk("R4", "ch_en during spike check", ch_en, 0);
        ticks(CHK);
        chk("R4", "ch_en after spike", ch_en, 1);
        chk("R4", "done unchanged", cycle_done, 0);
        chk("R4", "flt unchanged", flt, 0);

        // R5/R6: full cycle with a stable ground short
        cls_gnd = 1'b1;
        enter_cycle();
        ticks(CYC - 1);
        chk("R5", "done before last tick", cycle_done, 0);
        ticks(1);
        chk("R5", "done after last tick", cycle_done, 1);
        chk("R5", "ch_en after cycle", ch_en, 0);
        chk("R6", "flt ground short", flt, 4'b0001);
        trip = 1'b0;
        ticks(CHK);
        chk("R5", "restart after cycle", ch_en, 1);

        // R7: disarmed, so a new trip must not start a cycle
        cls_gnd = 1'b0;
        cls_vs = 1'b1;
        trip = 1'b1;
        step(1'b0);
        ticks(CHK + CYC + 2);
        chk("R7", "flt kept while disarmed", flt, 4'b0001);
        chk("R7", "ch_en held off", ch_en, 0);
        do_read();
        chk("R7", "done cleared by read", cycle_done, 0);
        chk("R7", "flt kept by read", flt, 4'b0001);
        trip = 1'b0;
        ticks(CHK);
        chk("R7", "ch_en back", ch_en, 1);

        // R6: flag dropped for one tick -> not latched
        enter_cycle();
        ticks(2);
        cls_vs = 1'b0;
        ticks(1);
        cls_vs = 1'b1;
        ticks(CYC - 3);
        chk("R6", "unstable flag not latched", flt, 0);
        chk("R6", "done after unstable cycle", cycle_done, 1);
        trip = 1'b0;
        ticks(CHK);
        do_read();

        // R9: abort mid-cycle keeps data and arming
        ton_flt = 4'b0100;
        ton_wr = 1'b1;
        step(1'b0);
        cls_vs = 1'b1;
        enter_cycle();
        ticks(2);
        diag_en = 1'b0;
        step(1'b0);
        ticks(CYC);
        chk("R9", "flt unchanged by abort", flt, 4'b0100);
        chk("R9", "done unchanged by abort", cycle_done, 0);
        trip = 1'b0;
        ticks(CHK);
        chk("R9", "restart after abort", ch_en, 1);
        diag_en = 1'b1;
        enter_cycle();
        ticks(CYC);
        chk("R9", "still armed after abort", cycle_done, 1);
        chk("R9", "cycle after abort latched", flt, 4'b0010);
        trip = 1'b0;
        ticks(CHK);

        // R8/R6: sweep of all class combinations over a preloaded open bit
        for (int c = 0; c < 8; c++) begin
            do_read();
            ton_flt = 4'b1000;
            ton_wr = 1'b1;
            step(1'b0);
            chk("R8", "open loaded", flt, 4'b1000);
            {cls_load, cls_vs, cls_gnd} = 3'(c);
            enter_cycle();
            ticks(CYC);
            chk("R6", "sweep flt", flt, (c == 0) ? 8 : c);
            chk("R8", "open bit after cycle", flt[3], (c == 0) ? 1 : 0);
            trip = 1'b0;
            ticks(CHK);
            chk("R3", "sweep restart", ch_en, 1);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule